// File: doc/BRIEF.md
# In-System Programming Host Sequencer

This block is the host side of an in-system programming session for a small microcontroller target. It drives the target's reset line and a four-wire serial link (SCK, MOSI, MISO, RESET). It then runs a whole flash-programming session on its own. The steps are: a power-up hold with both reset and clock low, a reset pulse, a settle wait, and the four-byte programming-enable instruction with a check of the target's echo.

Once the target is synchronised, the sequencer accepts 16-bit words from a valid/ready data port. Each word becomes two page-buffer load instructions, low byte first. After a full page, or after the word flagged as last, it issues a page commit. Between commits it either polls the target's ready/busy flag or waits a fixed number of cycles, as chosen by an input.

A failed echo causes a reset pulse and a fresh enable instruction. After a bounded number of failed attempts the session stops with an error flag. A completed session raises `done`.

Top module: `isp_host_seq`

## Requirements
- R1: After reset, `isp_sck`, `isp_mosi`, `isp_rst`, `wd_ready`, `done` and `sync_err` are all 0.
- R2: After `start`, `isp_rst` and `isp_sck` stay low for at least PWR_CYC cycles. Then `isp_rst` pulses high for at least PULSE_CYC cycles (PULSE_CYC ≥ 2) before returning low; every high pulse of `isp_rst` lasts at least PULSE_CYC cycles.
- R3: The first SCK rising edge of every enable instruction comes at least SETTLE_CYC cycles after the last falling edge of `isp_rst`.
- R4: Serial transfers are MSB first with SCK idle low. Each SCK high phase lasts exactly DIV clock cycles. MOSI changes only while SCK is low. MISO is sampled on the SCK rising edge.
- R5: The enable instruction is the four bytes 0xAC, 0x53, 0x00, 0x00. All four are always sent, including when the echo is wrong.
- R6: The byte received on MISO during the third enable byte is compared with 0x53. On a mismatch the sequencer pulses `isp_rst` high again, waits SETTLE_CYC and resends the enable instruction.
- R7: When MAX_RETRY enable attempts in a row fail, `sync_err` rises, no further instruction is sent and `wd_ready` is never asserted.
- R8: Each accepted word produces two loads in this order: 0x40, 0x00, {2'b00, offset}, data[7:0]; then 0x48, 0x00, {2'b00, offset}, data[15:8]. The offset counts words within the page from 0.
- R9: After PAGE_WORDS words, or after the word flagged with `wd_last`, the commit 0x4C, base[15:8], base[7:0], 0x00 is sent. `base` is the word address of the page's first word, starting at 0 and advancing by PAGE_WORDS per page.
- R10: With `poll_en` high, each commit is followed by the instruction 0xF0, 0x00, 0x00, 0x00. It is repeated while bit 0 of the fourth received byte is 1.
- R11: With `poll_en` low, the next instruction starts, or `done` rises, no sooner than WRITE_CYC cycles after the last SCK rising edge of a commit.
- R12: `done` rises only after the final page's commit, wait or poll has completed. It stays high until the next `start`, and is never high together with `sync_err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a programming session (idle, done or error state only) |
| poll_en | input | 1 | 1: poll ready/busy after commits; 0: fixed wait |
| wd_valid | input | 1 | Word source has a word |
| wd_data | input | 16 | Program word, low byte in bits 7:0 |
| wd_last | input | 1 | Marks the final word of the image |
| wd_ready | output | 1 | Sequencer accepts a word this cycle |
| isp_sck | output | 1 | Serial clock to target |
| isp_mosi | output | 1 | Serial data to target |
| isp_miso | input | 1 | Serial data from target |
| isp_rst | output | 1 | Target reset line (high = pulse) |
| done | output | 1 | Session finished |
| sync_err | output | 1 | Enable echo failed MAX_RETRY times |

## Verification
Three sessions exercise the sequencer, each against a behavioural target that records every four-byte instruction. A clean session spans one full page and a partial page in fixed-wait mode. It tells apart commit placement by count versus by the last flag, and it shows the wait time and the base-address stride. A second session fails the echo twice and keeps the target busy over several polls. It separates the retry path, with its reset pulse and settle, from the polling loop and its exit condition. A third session never synchronises, which shows the retry bound and that no word is ever requested. Every clock edge is also checked against the pin-level timing rules for SCK phase length, MOSI stability and reset pulse width.

// File: rtl/isp_pkg.sv
// Shared constants and state type for the in-system programming host.
// Assumes a target that uses four-byte serial instructions.
package isp_pkg;

    localparam logic [7:0] OP_ENABLE = 8'hAC;
    localparam logic [7:0] EN_KEY    = 8'h53;
    localparam logic [7:0] OP_LOADLO = 8'h40;
    localparam logic [7:0] OP_LOADHI = 8'h48;
    localparam logic [7:0] OP_COMMIT = 8'h4C;
    localparam logic [7:0] OP_POLL   = 8'hF0;

    typedef enum logic [3:0] {
        S_IDLE, S_PWR, S_PULSE, S_SETTLE, S_XFER, S_CHKEN, S_FETCH,
        S_SENDHI, S_AFTHI, S_AFTCMT, S_POLLCHK, S_WAIT, S_NEXT, S_DONE, S_ERR
    } host_state_t;

endpackage

// File: rtl/isp_wait_timer.sv
// Down-counting delay timer. A load pulse sets the count; zero_o is high
// once the count has run out. Assumes the loaded value is at least 1.
module isp_wait_timer #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);

    logic [W-1:0] cnt;

    // Load on request, otherwise count down towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (load_i)      cnt <= val_i;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign zero_o = (cnt == '0);

    // R11
    tmr_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load_i) |-> (cnt <= $past(cnt)));

endmodule

// File: rtl/isp_byte_shift.sv
// One-byte serial shifter, clock idle low, MSB first. MOSI is updated on
// SCK falling edges and MISO is sampled on SCK rising edges. Each SCK
// phase lasts DIV system clocks. Assumes go_i is only pulsed while idle.
module isp_byte_shift #(
    parameter int DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go_i,
    input  logic [7:0] tx_i,
    input  logic       miso_i,
    output logic       sck_o,
    output logic       mosi_o,
    output logic [7:0] rx_o,
    output logic       done_o
);

    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic          busy;
    logic [CW-1:0] cnt;
    logic [2:0]    bitn;
    logic [7:0]    sreg;

    // Phase counter, clock toggling, shifting and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0; cnt <= '0; bitn <= '0; sreg <= '0;
            sck_o <= 1'b0; rx_o <= '0; done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (!busy) begin
                if (go_i) begin
                    busy <= 1'b1; sreg <= tx_i; cnt <= '0; bitn <= '0;
                end
            end else if (cnt == CW'(DIV - 1)) begin
                cnt <= '0;
                if (!sck_o) begin
                    sck_o <= 1'b1;
                    rx_o  <= {rx_o[6:0], miso_i};
                end else begin
                    sck_o <= 1'b0;
                    if (bitn == 3'd7) begin
                        busy   <= 1'b0;
                        done_o <= 1'b1;
                    end else begin
                        bitn <= bitn + 3'd1;
                        sreg <= {sreg[6:0], 1'b0};
                    end
                end
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign mosi_o = busy ? sreg[7] : 1'b0;

    // R4
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_o && $past(sck_o)) |-> $stable(mosi_o));

endmodule

// File: rtl/isp_host_seq.sv
// In-system programming host sequencer. Runs power-up hold, reset pulse,
// settle wait and the enable handshake with bounded retries, then turns
// words from a valid/ready port into page loads, commits each page, and
// polls or waits after each commit. Assumes PAGE_WORDS <= 64.
module isp_host_seq
    import isp_pkg::*;
#(
    parameter int DIV        = 4,
    parameter int PWR_CYC    = 1000,
    parameter int PULSE_CYC  = 8,
    parameter int SETTLE_CYC = 1000000,
    parameter int WRITE_CYC  = 225000,
    parameter int MAX_RETRY  = 4,
    parameter int PAGE_WORDS = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        poll_en,
    input  logic        wd_valid,
    input  logic [15:0] wd_data,
    input  logic        wd_last,
    output logic        wd_ready,
    output logic        isp_sck,
    output logic        isp_mosi,
    input  logic        isp_miso,
    output logic        isp_rst,
    output logic        done,
    output logic        sync_err
);

    localparam int OFF_W = (PAGE_WORDS > 1) ? $clog2(PAGE_WORDS) : 1;
    localparam int RC_W  = $clog2(MAX_RETRY + 1);

    host_state_t      st, ret_st;
    logic [31:0]      instr;
    logic [1:0]       idx;
    logic             spi_go, spi_done;
    logic [7:0]       spi_rx, tx_byte, rx_b2, rx_b3;
    logic             tmr_load, tmr_zero, tmr_ok;
    logic [31:0]      tmr_val;
    logic [RC_W-1:0]  retries;
    logic [15:0]      base;
    logic [OFF_W-1:0] off;
    logic [7:0]       hi_q;
    logic             last_q, rst_q, done_q, err_q;

    // Pick the instruction byte being sent.
    always_comb begin
        case (idx)
            2'd0:    tx_byte = instr[31:24];
            2'd1:    tx_byte = instr[23:16];
            2'd2:    tx_byte = instr[15:8];
            default: tx_byte = instr[7:0];
        endcase
    end

    assign tmr_ok = tmr_zero && !tmr_load;

    // Session sequencing: pins, retries, word intake and page bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE; ret_st <= S_IDLE; instr <= '0; idx <= '0;
            spi_go <= 1'b0; rx_b2 <= '0; rx_b3 <= '0;
            tmr_load <= 1'b0; tmr_val <= '0; retries <= '0;
            base <= '0; off <= '0; hi_q <= '0; last_q <= 1'b0;
            rst_q <= 1'b0; done_q <= 1'b0; err_q <= 1'b0;
        end else begin
            spi_go   <= 1'b0;
            tmr_load <= 1'b0;
            case (st)
                S_IDLE, S_DONE, S_ERR: if (start) begin
                    done_q <= 1'b0; err_q <= 1'b0; retries <= '0;
                    rst_q <= 1'b0; tmr_load <= 1'b1; tmr_val <= 32'(PWR_CYC);
                    st <= S_PWR;
                end
                S_PWR: if (tmr_ok) begin
                    rst_q <= 1'b1; tmr_load <= 1'b1; tmr_val <= 32'(PULSE_CYC);
                    st <= S_PULSE;
                end
                S_PULSE: if (tmr_ok) begin
                    rst_q <= 1'b0; tmr_load <= 1'b1; tmr_val <= 32'(SETTLE_CYC);
                    st <= S_SETTLE;
                end
                S_SETTLE: if (tmr_ok) begin
                    instr <= {OP_ENABLE, EN_KEY, 16'h0000}; ret_st <= S_CHKEN;
                    idx <= '0; spi_go <= 1'b1; st <= S_XFER;
                end
                S_XFER: if (spi_done) begin
                    if (idx == 2'd2) rx_b2 <= spi_rx;
                    if (idx == 2'd3) begin
                        rx_b3 <= spi_rx; st <= ret_st;
                    end else begin
                        idx <= idx + 2'd1; spi_go <= 1'b1;
                    end
                end
                S_CHKEN: begin
                    if (rx_b2 == EN_KEY) begin
                        base <= '0; off <= '0; st <= S_FETCH;
                    end else if (retries == RC_W'(MAX_RETRY - 1)) begin
                        err_q <= 1'b1; st <= S_ERR;
                    end else begin
                        retries <= retries + 1'b1; rst_q <= 1'b1;
                        tmr_load <= 1'b1; tmr_val <= 32'(PULSE_CYC); st <= S_PULSE;
                    end
                end
                S_FETCH: if (wd_valid) begin
                    hi_q <= wd_data[15:8]; last_q <= wd_last;
                    instr <= {OP_LOADLO, 8'h00, 8'(off), wd_data[7:0]};
                    ret_st <= S_SENDHI; idx <= '0; spi_go <= 1'b1; st <= S_XFER;
                end
                S_SENDHI: begin
                    instr <= {OP_LOADHI, 8'h00, 8'(off), hi_q};
                    ret_st <= S_AFTHI; idx <= '0; spi_go <= 1'b1; st <= S_XFER;
                end
                S_AFTHI: begin
                    if (last_q || off == OFF_W'(PAGE_WORDS - 1)) begin
                        instr <= {OP_COMMIT, base, 8'h00};
                        ret_st <= S_AFTCMT; idx <= '0; spi_go <= 1'b1; st <= S_XFER;
                    end else begin
                        off <= off + 1'b1; st <= S_FETCH;
                    end
                end
                S_AFTCMT, S_POLLCHK: begin
                    if (st == S_POLLCHK && !rx_b3[0]) begin
                        st <= S_NEXT;
                    end else if (st == S_POLLCHK || poll_en) begin
                        instr <= {OP_POLL, 24'h000000};
                        ret_st <= S_POLLCHK; idx <= '0; spi_go <= 1'b1; st <= S_XFER;
                    end else begin
                        tmr_load <= 1'b1; tmr_val <= 32'(WRITE_CYC); st <= S_WAIT;
                    end
                end
                S_WAIT: if (tmr_ok) st <= S_NEXT;
                S_NEXT: begin
                    if (last_q) begin
                        done_q <= 1'b1; st <= S_DONE;
                    end else begin
                        base <= base + 16'(PAGE_WORDS); off <= '0; st <= S_FETCH;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    isp_byte_shift #(.DIV(DIV)) u_shift (
        .clk(clk), .rst_n(rst_n), .go_i(spi_go), .tx_i(tx_byte),
        .miso_i(isp_miso), .sck_o(isp_sck), .mosi_o(isp_mosi),
        .rx_o(spi_rx), .done_o(spi_done)
    );

    isp_wait_timer #(.W(32)) u_timer (
        .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .val_i(tmr_val),
        .zero_o(tmr_zero)
    );

    assign wd_ready = (st == S_FETCH);
    assign isp_rst  = rst_q;
    assign done     = done_q;
    assign sync_err = err_q;

    // R4
    sck_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != S_XFER) |-> !isp_sck);
    // R2
    rst_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(isp_rst) |-> $past(isp_rst, 2));
    // R12
    done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && sync_err));
    // R7
    err_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err |-> !wd_ready);
    // R2
    no_sck_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        isp_rst |-> !isp_sck);

endmodule

// File: tb/tb_isp_host_seq.sv
module tb_isp_host_seq;

    localparam int DIV = 2, PWR = 10, PULSE = 4, SETTLE = 50, WRITE = 40;
    localparam int MAXR = 3, PAGE = 4;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, poll_en = 1'b0;
    logic wd_valid = 1'b0, wd_last = 1'b0;
    logic [15:0] wd_data = '0;
    logic wd_ready, isp_sck, isp_mosi, isp_rst, done, sync_err;
    logic isp_miso = 1'b0;

    isp_host_seq #(.DIV(DIV), .PWR_CYC(PWR), .PULSE_CYC(PULSE),
        .SETTLE_CYC(SETTLE), .WRITE_CYC(WRITE), .MAX_RETRY(MAXR),
        .PAGE_WORDS(PAGE)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .poll_en(poll_en),
        .wd_valid(wd_valid), .wd_data(wd_data), .wd_last(wd_last),
        .wd_ready(wd_ready), .isp_sck(isp_sck), .isp_mosi(isp_mosi),
        .isp_miso(isp_miso), .isp_rst(isp_rst), .done(done), .sync_err(sync_err));

    always #10 clk = ~clk;

    int checks = 0, errors = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- behavioural target ----------------
    logic [7:0] in_sh = '0, cur_out = '0;
    logic [7:0] bytes [4];
    int bitc = 0, bidx = 0, fail_left = 0, busy_left = 0;
    logic nxt_bit = 1'b0;
    logic [31:0] got_q[$];
    int got_start[$], got_end[$], got_since[$];
    int cur_start = 0, cur_since = 0, last_fall = 0;

    always @(posedge isp_sck, negedge isp_sck, posedge isp_rst) begin
        if (isp_rst) begin
            bitc = 0; bidx = 0; cur_out = 8'h00; nxt_bit = 1'b0; isp_miso = 1'b0;
        end else if (isp_sck) begin
            in_sh = {in_sh[6:0], isp_mosi};
            if (bitc == 0 && bidx == 0) begin
                cur_start = cyc; cur_since = cyc - last_fall;
            end
            bitc++;
            if (bitc == 8) begin
                bitc = 0;
                bytes[bidx] = in_sh;
                cur_out = 8'h00;
                if (bidx == 3) begin
                    got_q.push_back({bytes[0], bytes[1], bytes[2], bytes[3]});
                    got_start.push_back(cur_start);
                    got_end.push_back(cyc);
                    got_since.push_back(cur_since);
                    bidx = 0;
                end else begin
                    bidx++;
                    if (bytes[0] == 8'hAC && bidx == 2) begin
                        if (fail_left > 0) begin fail_left--; cur_out = 8'h00; end
                        else cur_out = bytes[1];
                    end
                    if (bytes[0] == 8'hF0 && bidx == 3) begin
                        if (busy_left > 0) begin busy_left--; cur_out = 8'h01; end
                    end
                end
                nxt_bit = cur_out[7];
            end else begin
                nxt_bit = cur_out[7 - bitc];
            end
        end else begin
            isp_miso = nxt_bit;
        end
    end

    // ---------------- per-clock pin rules ----------------
    logic p_sck = 1'b0, p_mosi = 1'b0, p_rst = 1'b0;
    int hi_len = 0, rst_len = 0, rises = 0, first_rise = -1;
    bit ready_seen = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            // R4 MOSI held while SCK high
            if (isp_sck && p_sck && isp_mosi != p_mosi)
                chk(1'b0, "R4 mosi moved with sck high", isp_mosi, p_mosi);
            if (isp_sck) hi_len++;
            if (!isp_sck && p_sck) begin
                if (hi_len != DIV) chk(1'b0, "R4 sck high phase", hi_len, DIV);
                hi_len = 0;
            end
            // R2 no clock while reset pulses
            if (isp_rst && isp_sck) chk(1'b0, "R2 sck during reset pulse", 1, 0);
            if (isp_rst) rst_len++;
            if (isp_rst && !p_rst) begin
                rises++;
                if (first_rise < 0) first_rise = cyc;
            end
            if (!isp_rst && p_rst) begin
                if (rst_len < PULSE) chk(1'b0, "R2 reset pulse width", rst_len, PULSE);
                rst_len = 0; last_fall = cyc;
            end
            if (wd_ready) ready_seen = 1'b1;
            if (wd_ready && isp_sck) chk(1'b0, "R8 ready during transfer", 1, 0);
        end
        p_sck = isp_sck; p_mosi = isp_mosi; p_rst = isp_rst;
    end

    // ---------------- stimulus helpers ----------------
    function automatic logic [15:0] wval(input int i);
        return 16'hA05C + 16'(i * 16'h1111);
    endfunction

    int done_cyc = 0;
    bit timed_out = 1'b0;

    task automatic feed(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wd_valid = 1'b1; wd_data = wval(i); wd_last = (i == n - 1);
            forever begin
                if (wd_ready || sync_err || timed_out) break;
                @(negedge clk);
            end
            if (sync_err || timed_out) break;
            @(posedge clk);
        end
        @(negedge clk);
        wd_valid = 1'b0; wd_last = 1'b0;
    endtask

    task automatic wait_end();
        int t = 0;
        while (!done && !sync_err && t < 60000) begin
            @(negedge clk); t++;
        end
        if (t >= 60000) begin
            timed_out = 1'b1;
            chk(1'b0, "watchdog expired", t, 0);
        end
        done_cyc = cyc;
    endtask

    logic [31:0] exp_q[$];
    int start_cyc = 0;

    task automatic run(input int nw, input bit pol, input int nfail, input int nbusy);
        got_q.delete(); got_start.delete(); got_end.delete(); got_since.delete();
        exp_q.delete();
        fail_left = nfail; busy_left = nbusy; rises = 0; first_rise = -1;
        ready_seen = 1'b0; timed_out = 1'b0;
        @(negedge clk); poll_en = pol; start = 1'b1; start_cyc = cyc;
        @(negedge clk); start = 1'b0;
        fork
            feed(nw);
            wait_end();
        join
    endtask

    task automatic build(input int nw, input int nen, input bit pol, input int nbusy);
        for (int e = 0; e < nen; e++) exp_q.push_back(32'hAC530000);
        for (int i = 0; i < nw; i++) begin
            int o = i % PAGE;
            exp_q.push_back({8'h40, 8'h00, 8'(o), wval(i)[7:0]});
            exp_q.push_back({8'h48, 8'h00, 8'(o), wval(i)[15:8]});
            if (o == PAGE - 1 || i == nw - 1) begin
                exp_q.push_back({8'h4C, 16'(i - o), 8'h00});
                if (pol) for (int p = 0; p <= nbusy; p++) exp_q.push_back(32'hF0000000);
            end
        end
    endtask

    task automatic compare(input string tag);
        chk(got_q.size() == exp_q.size(), {tag, " instruction count"}, got_q.size(), exp_q.size());
        for (int k = 0; k < exp_q.size() && k < got_q.size(); k++)
            chk(got_q[k] == exp_q[k], tag, got_q[k], exp_q[k]);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        chk({isp_sck, isp_mosi, isp_rst, wd_ready, done, sync_err} == 6'b0,
            "R1 reset outputs", {isp_sck, isp_mosi, isp_rst, wd_ready, done, sync_err}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk({isp_sck, isp_rst, wd_ready, done, sync_err} == 5'b0, "R1 idle outputs",
            {isp_sck, isp_rst, wd_ready, done, sync_err}, 0);

        // Session A: clean sync, six words, fixed wait
        run(6, 1'b0, 0, 0);
        build(6, 1, 1'b0, 0);
        compare("R8 R9 R5 session A");
        chk(first_rise - start_cyc >= PWR, "R2 power-up hold", first_rise - start_cyc, PWR);
        chk(rises == 1, "R2 single pulse", rises, 1);
        chk(got_since.size() > 0 && got_since[0] >= SETTLE, "R3 settle before enable",
            got_since.size() > 0 ? got_since[0] : -1, SETTLE);
        for (int k = 0; k + 1 < got_q.size(); k++)
            if (got_q[k][31:24] == 8'h4C)
                chk(got_start[k+1] - got_end[k] >= WRITE, "R11 wait after commit",
                    got_start[k+1] - got_end[k], WRITE);
        if (got_end.size() > 0)
            chk(done_cyc - got_end[got_end.size()-1] >= WRITE, "R11 R12 done after wait",
                done_cyc - got_end[got_end.size()-1], WRITE);
        chk(done && !sync_err, "R12 done raised", {done, sync_err}, 2'b10);
        repeat (20) @(negedge clk);
        chk(done == 1'b1, "R12 done sticky", done, 1);

        // Session B: two failed echoes, busy polling, exact page
        run(4, 1'b1, 2, 3);
        build(4, 3, 1'b1, 3);
        compare("R6 R10 R5 session B");
        chk(rises == 3, "R6 retry pulses", rises, 3);
        for (int k = 0; k < got_q.size(); k++)
            if (got_q[k] == 32'hAC530000)
                chk(got_since[k] >= SETTLE, "R3 settle before each enable", got_since[k], SETTLE);
        chk(done && !sync_err, "R12 done after poll", {done, sync_err}, 2'b10);

        // Session C: never synchronises
        run(3, 1'b0, 9, 0);
        build(0, MAXR, 1'b0, 0);
        compare("R7 R5 session C");
        chk(sync_err && !done, "R7 sync_err raised", {done, sync_err}, 2'b01);
        chk(!ready_seen, "R7 no word requested", ready_seen, 0);
        repeat (30) @(negedge clk);
        chk(got_q.size() == MAXR, "R7 silent after error", got_q.size(), MAXR);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule